// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general purpose I/O port that sits on a simple byte-wide memory-mapped register bus. It holds two registers. The first is a direction register that sets whether each pin drives its pad. The second is an output value register that sets the level driven on each output pin. Each pin's output enable comes straight from its direction bit. The pad inputs pass through a two-flop synchronizer before anything reads them.

Data accesses use part of the address as a per-pin mask. Address bits [9:2] select which pins a data access touches, so pin n is reached by an address that has bit n+2 set. Software can therefore change one pin, or any group of pins, with a single write and without a read-modify-write sequence. A data write only changes pins that are selected by the mask and are set as outputs. To set a pin to a known level, software first switches the pin to output and then writes the value again. Reads return their data one cycle after the request.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, pad_oe, pad_out and bus_rdata are all zero, so every pin starts as an input.
- R2: The direction register is at byte offset 0x400. Bit n set to 1 makes pin n an output. A read of 0x400 returns the register, and pad_oe always equals it.
- R3: A write to the data window (offset bits [11:10] = 0 and [1:0] = 0) sets output bit n to bus_wdata[n] when address bit n+2 is 1 and direction bit n is 1. All other output bits keep their value, and pad_out always equals the output register.
- R4: A data write has no effect on a pin whose direction bit is 0. Writing the same value again after the pin becomes an output sets the pin.
- R5: A data read returns 0 in bit n when address bit n+2 is 0. Otherwise bit n is the output register bit for an output pin, or the synchronized pad input for an input pin.
- R6: A pad input change becomes visible only to a read whose capture edge is the third rising clock edge after the change, or a later edge, because the input passes through a two-flop synchronizer.
- R7: bus_rdata is registered. It takes its new value at the clock edge where bus_sel=1 and bus_wr=0 are sampled, and it holds that value in cycles with no read.
- R8: An access to any other offset, including one with bits [1:0] nonzero, reads 0 and leaves the direction and output registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Output values to pads |
| pad_oe | output | 8 | Output enables to pads |

## Verification
The bench writes through all 256 address masks in two direction settings: all pins as outputs, and the low four pins as outputs. This separates mask handling from direction gating. It then reads through all 256 masks with a fixed pad pattern that differs from the output register, which shows whether each read bit comes from the output register, from the pad input, or is forced to zero. A pad change followed by back-to-back reads measures the synchronizer depth. Writes and reads at unmapped and misaligned offsets show that those accesses leave both registers unchanged and read as zero.

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
  parameter int NPIN = 8,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DIR_OFS = 12'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);
  localparam int MLO = 2;
  localparam int MHI = NPIN + MLO - 1;

  logic [NPIN-1:0] dir_q, out_q, sync1_q, sync2_q, rdata_q, rd_val, mask, wr_en;
  logic data_hit, dir_hit;

  assign mask     = bus_addr[MHI:MLO];
  assign data_hit = (bus_addr[ADDR_W-1:MHI+1] == '0) && (bus_addr[1:0] == 2'b00);
  assign dir_hit  = (bus_addr == DIR_OFS);
  assign wr_en    = (bus_sel && bus_wr && data_hit) ? (mask & dir_q) : '0;

  always_comb begin
    if (data_hit)     rd_val = ((dir_q & out_q) | (~dir_q & sync2_q)) & mask;
    else if (dir_hit) rd_val = dir_q;
    else              rd_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      rdata_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      out_q   <= (out_q & ~wr_en) | (bus_wdata & wr_en);
      if (bus_sel && bus_wr && dir_hit) dir_q <= bus_wdata;
      if (bus_sel && !bus_wr) rdata_q <= rd_val;
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = out_q;
  assign pad_oe    = dir_q;
endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
  parameter int NPIN = 8,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] DIR_OFS = 12'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_rdata,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe
);
  logic in_data, in_dir;
  assign in_data = (bus_addr[ADDR_W-1:NPIN+2] == '0) && (bus_addr[1:0] == 2'b00);
  assign in_dir  = (bus_addr == DIR_OFS);

  p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && in_dir) |=> $stable(pad_oe));

  p_out_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(pad_out));

  p_out_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && in_data) |=>
      (((pad_out ^ $past(pad_out)) & ~($past(pad_oe) & $past(bus_addr[NPIN+1:2]))) == '0));

  p_rd_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && in_data) |=> ((bus_rdata & ~$past(bus_addr[NPIN+1:2])) == '0));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  p_unmapped_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !in_data && !in_dir) |=> (bus_rdata == '0));

  p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !in_data && !in_dir) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_masked_port gpio_masked_port_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_gpio_masked_port.sv
module tb_gpio_masked_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, pad_in = '0;
  logic [7:0] bus_rdata, pad_out, pad_oe;
  logic [7:0] dir_m, out_m, rd;
  int checks = 0, fails = 0;

  gpio_masked_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rdt(input logic [11:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic data_write(input logic [7:0] m, input logic [7:0] d);
    wr({2'b00, m, 2'b00}, d);
    out_m = (out_m & ~(m & dir_m)) | (d & m & dir_m);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    dir_m = 0; out_m = 0;
    repeat (2) @(negedge clk);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);

    wr(12'h400, 8'hFF); dir_m = 8'hFF;
    check("R2 pad_oe", pad_oe, 8'hFF);
    rdt(12'h400, rd); check("R2 dir readback", rd, 8'hFF);

    for (int m = 0; m < 256; m++) begin
      data_write(m[7:0], 8'(m * 37 + 5));
      check("R3 pad_out", pad_out, out_m);
    end

    wr(12'h400, 8'h0F); dir_m = 8'h0F;
    check("R2 pad_oe partial", pad_oe, 8'h0F);
    for (int m = 0; m < 256; m++) begin
      data_write(m[7:0], ~pad_out);
      check("R4 input pins untouched", pad_out, out_m);
    end

    data_write(8'h80, 8'h00);
    wr(12'h400, 8'h8F); dir_m = 8'h8F;
    data_write(8'h80, 8'h80);
    check("R4 rewrite after switch", pad_out & 8'h80, 8'h80);
    data_write(8'h80, 8'h00);
    check("R4 clear pin 7", pad_out & 8'h80, 8'h00);
    wr(12'h400, 8'h0F); dir_m = 8'h0F;

    pad_in = 8'hA5;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m++) begin
      rdt({2'b00, m[7:0], 2'b00}, rd);
      check("R5 masked read", rd, ((dir_m & out_m) | (~dir_m & pad_in)) & m[7:0]);
    end

    wr(12'h400, 8'h00); dir_m = 8'h00;
    pad_in = 8'h3C;
    rdt(12'h3FC, rd); check("R6 first read old", rd, 8'hA5);
    rdt(12'h3FC, rd); check("R6 second read old", rd, 8'hA5);
    rdt(12'h3FC, rd); check("R6 third read new", rd, 8'h3C);

    repeat (4) @(negedge clk);
    check("R7 rdata holds", bus_rdata, 8'h3C);
    rdt(12'h0F0, rd); check("R7 new read", rd, 8'h3C & 8'h3C);
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    check("R7 hold after pad change", bus_rdata, 8'h3C);

    wr(12'h400, 8'hF0); dir_m = 8'hF0;
    data_write(8'hFF, 8'h50);
    wr(12'h404, 8'hFF);
    wr(12'h800, 8'hFF);
    wr(12'h3FD, 8'hFF);
    wr(12'h402, 8'h00);
    check("R8 pad_oe unchanged", pad_oe, 8'hF0);
    check("R8 pad_out unchanged", pad_out, out_m);
    rdt(12'h404, rd); check("R8 read 0x404", rd, 8'h00);
    rdt(12'h3FC, rd);
    rdt(12'hC00, rd); check("R8 read 0xC00", rd, 8'h00);
    rdt(12'h3FC, rd);
    rdt(12'h3FE, rd); check("R8 misaligned read", rd, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule